// File: doc/BRIEF.md
# Keyed Multi-CRC Authentication Hash

This core turns a 32-bit challenge word into an 8-bit authentication byte. It holds four small CRC registers, each eight bits wide. Two secret words control it. The function key sets, for each register, its feedback taps and the challenge byte lane it reads first. The seed key supplies the value each register starts from.

A host first pulses `loadSeed` to preset the four registers from the seed key. It then presents a challenge and pulses `start`. The core shifts the challenge through all four registers at once, one bit per clock, so a run takes 32 cycles. At the end `done` rises for one cycle. From that cycle on, `result` holds the XOR of the four register contents.

A second `start` without a fresh `loadSeed` continues from whatever the registers hold. This lets several challenges be chained into one hash.

Top module: `mch_hash_core`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0x00, because all four CRC registers are cleared.
- R2: When `loadSeed` is sampled high and no run is in progress, register k (k = 0..3) is loaded from `seedKey[8k+7:8k]`. From the next cycle `result` equals the XOR of the four seed bytes.
- R3: When `start` is sampled high and no run is in progress, a run begins. The run takes 32 clock edges, and `done` is high for exactly the one cycle after the 32nd edge.
- R4: For register k, the function-key byte b = `funcKey[8k+7:8k]` gives the polynomial taps P = (b & 0x3E) | 0x01, with x^8 implied. On each step, with s the state and d the input bit, the update is s' = (s<<1)&0xFF, XORed with P when s[7]^d is 1.
- R5: Bits b[7:6] of that byte pick the first challenge lane L, where lane j is `challenge[8j+7:8j]`. On step i (0..31) register k reads lane (L + i/8) mod 4 at bit position 7 - (i mod 8), so each lane is fed MSB first.
- R6: `result` is always the bitwise XOR of the four CRC registers. It does not change in cycles where no load and no step takes place.
- R7: A `start` with no `loadSeed` since the last run hashes onward from the current register contents.
- R8: `start` and `loadSeed` pulses that arrive while a run is in progress are ignored. They neither change the result nor move the timing of `done`.
- R9: The challenge and the function key are captured on the accepted `start`. Changing either input during the run has no effect on that run.
- R10: If `loadSeed` and `start` are sampled high in the same idle cycle, the seeds are loaded and the run starts from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadSeed | input | 1 | Preset the CRC registers from `seedKey` |
| start | input | 1 | Begin hashing `challenge` |
| challenge | input | 32 | Challenge word, captured on start |
| funcKey | input | 32 | Function secret: taps and first lane per register |
| seedKey | input | 32 | Seed secret: initial value per register |
| done | output | 1 | One-cycle pulse when a run completes |
| result | output | 8 | XOR of the four CRC registers |

## Verification
The bench builds the core with its default constants: four registers, an 8-bit CRC width and a 32-bit challenge. With these values each of the four first-lane choices occurs, and the lane rotation wraps from lane 3 back to lane 0 partway through a run. The width of the tap field also leaves x^6 and x^7 fixed at zero, and the bench exercises that. Random keys and challenges are mixed with chained runs, overlapping pulses and inputs that change mid-run. Every cycle is compared against a bit-serial model.

// File: rtl/mch_pkg.sv
package mch_pkg;
  localparam int NUM_ENG    = 4;
  localparam int CRC_W      = 8;
  localparam int CHAL_W     = NUM_ENG * CRC_W;
  localparam int LANE_SEL_W = $clog2(NUM_ENG);
  localparam int LANE_IDX_W = $clog2(CRC_W);
  localparam int IDX_W      = LANE_SEL_W + LANE_IDX_W;
  localparam int TAP_W      = CRC_W - LANE_SEL_W;

  typedef struct packed {
    logic             loadSeed;
    logic             capture;
    logic             step;
    logic [IDX_W-1:0] bitIdx;
  } mch_strobe_t;
endpackage

// File: rtl/mch_ctrl.sv
module mch_ctrl
  import mch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        loadSeed,
  output mch_strobe_t strobe,
  output logic        done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAL_W - 1);

  logic             running;
  logic [IDX_W-1:0] cnt;

  always_comb begin
    strobe.loadSeed = loadSeed & ~running;
    strobe.capture  = start & ~running;
    strobe.step     = running;
    strobe.bitIdx   = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (running) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_IDX) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end else if (start) begin
        running <= 1'b1;
        cnt     <= '0;
      end
    end
  end

  // R3: done is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: no new capture can follow an edge where a step was taken, except after the final step
  a_r8_no_restart_midrun: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && cnt != LAST_IDX) |=> !strobe.capture && !strobe.loadSeed);
endmodule

// File: rtl/mch_datapath.sv
module mch_datapath
  import mch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mch_strobe_t       strobe,
  input  logic [CHAL_W-1:0] challenge,
  input  logic [CHAL_W-1:0] funcKey,
  input  logic [CHAL_W-1:0] seedKey,
  output logic [CRC_W-1:0]  result
);
  localparam logic [CRC_W-1:0] TAP_MASK = CRC_W'(((1 << TAP_W) - 1) & ~1);

  logic [CHAL_W-1:0]              chalReg;
  logic [CHAL_W-1:0]              keyReg;
  logic [NUM_ENG-1:0][CRC_W-1:0]  engOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chalReg <= '0;
      keyReg  <= '0;
    end else if (strobe.capture) begin
      chalReg <= challenge;
      keyReg  <= funcKey;
    end
  end

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    logic [CRC_W-1:0]      keyByte;
    logic [CRC_W-1:0]      poly;
    logic [LANE_SEL_W-1:0] lane;
    logic                  inBit;
    logic                  fb;
    logic [CRC_W-1:0]      crc;
    logic [CRC_W-1:0]      crcNext;

    always_comb begin
      keyByte = keyReg[e*CRC_W +: CRC_W];
      poly    = (keyByte & TAP_MASK) | CRC_W'(1);
      lane    = keyByte[CRC_W-1 -: LANE_SEL_W] + strobe.bitIdx[IDX_W-1 -: LANE_SEL_W];
      inBit   = chalReg[{lane, ~strobe.bitIdx[LANE_IDX_W-1:0]}];
      fb      = crc[CRC_W-1] ^ inBit;
      crcNext = {crc[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                crc <= '0;
      else if (strobe.loadSeed) crc <= seedKey[e*CRC_W +: CRC_W];
      else if (strobe.step)     crc <= crcNext;
    end

    assign engOut[e] = crc;

    // R2: a seed load presets this register from its seed byte
    a_r2_seed_byte: assert property (@(posedge clk) disable iff (!rstN)
      strobe.loadSeed |=> engOut[e] == $past(seedKey[e*CRC_W +: CRC_W]));
  end

  always_comb begin
    result = '0;
    for (int e = 0; e < NUM_ENG; e++) result ^= engOut[e];
  end

  // R9: captured challenge and key hold for the whole run
  a_r9_operands_held: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> $stable(chalReg) && $stable(keyReg));

  // R6: registers keep their value when neither loading nor stepping
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadSeed && !strobe.step) |=> $stable(engOut));
endmodule

// File: rtl/mch_hash_core.sv
module mch_hash_core
  import mch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadSeed,
  input  logic              start,
  input  logic [CHAL_W-1:0] challenge,
  input  logic [CHAL_W-1:0] funcKey,
  input  logic [CHAL_W-1:0] seedKey,
  output logic              done,
  output logic [CRC_W-1:0]  result
);
  mch_strobe_t strobe;

  mch_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .loadSeed (loadSeed),
    .strobe   (strobe),
    .done     (done)
  );

  mch_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .challenge (challenge),
    .funcKey   (funcKey),
    .seedKey   (seedKey),
    .result    (result)
  );

  logic [IDX_W:0] stepRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              stepRun <= '0;
    else if (strobe.capture) stepRun <= '0;
    else if (strobe.step)    stepRun <= stepRun + 1'b1;
  end

  // R3: done follows exactly CHAL_W consecutive steps
  a_r3_thirty_two_steps: assert property (@(posedge clk) disable iff (!rstN)
    done |-> stepRun == (IDX_W+1)'(CHAL_W) && $past(strobe.step));
endmodule

// File: tb/sim_mch_hash_core.sv
module sim_mch_hash_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadSeed = 1'b0;
  logic        start = 1'b0;
  logic [31:0] challenge = '0;
  logic [31:0] funcKey = '0;
  logic [31:0] seedKey = '0;
  logic        done;
  logic [7:0]  result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mch_hash_core u0 (
    .clk(clk), .rstN(rstN), .loadSeed(loadSeed), .start(start),
    .challenge(challenge), .funcKey(funcKey), .seedKey(seedKey),
    .done(done), .result(result)
  );

  // behavioural reference model
  int mState [4];
  int mBusy, mCnt, mDone;
  int mKey, mChal;

  function automatic int modelResult();
    int r = 0;
    for (int k = 0; k < 4; k++) r ^= mState[k];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 4; k++) mState[k] = 0;
      mBusy = 0; mCnt = 0; mDone = 0; mKey = 0; mChal = 0;
    end else begin
      mDone = 0;
      if (mBusy != 0) begin
        for (int k = 0; k < 4; k++) begin
          int kb, poly, ln, bitv, fb;
          kb   = (mKey >> (8*k)) & 255;
          poly = (kb & 8'h3E) | 1;
          ln   = (((kb >> 6) & 3) + mCnt / 8) % 4;
          bitv = (mChal >> (ln*8 + 7 - (mCnt % 8))) & 1;
          fb   = ((mState[k] >> 7) & 1) ^ bitv;
          mState[k] = ((mState[k] << 1) & 255) ^ (fb != 0 ? poly : 0);
        end
        mCnt++;
        if (mCnt == 32) begin mBusy = 0; mDone = 1; end
      end else begin
        if (loadSeed) for (int k = 0; k < 4; k++) mState[k] = (seedKey >> (8*k)) & 255;
        if (start) begin mBusy = 1; mCnt = 0; mKey = funcKey; mChal = challenge; end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R3 done timing, R6 result)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R3 done vs model", {31'b0, done}, mDone);
      chk("R6 result vs model", {24'b0, result}, modelResult());
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic runTo(input logic [31:0] c, input logic [31:0] fk, input bit withLoad,
                       input logic [31:0] sk);
    challenge = c; funcKey = fk; seedKey = sk;
    loadSeed = withLoad; start = 1'b1;
    tick();
    loadSeed = 1'b0; start = 1'b0;
    repeat (32) tick();
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1 done at reset", {31'b0, done}, 0);
    chk("R1 result at reset", {24'b0, result}, 0);
    rstN = 1'b1;
    tick();
    chk("R1 result after release", {24'b0, result}, 0);

    // R2 seed load
    seedKey = 32'h01020408; loadSeed = 1'b1; tick(); loadSeed = 1'b0;
    chk("R2 seed xor", {24'b0, result}, 32'h0F);
    tick();
    chk("R2 result held", {24'b0, result}, 32'h0F);

    // R4 polynomial and lane: engine0 key 0xFF, others 0x00
    runTo(32'h00000001, 32'h000000FF, 1'b1, 32'h0);
    chk("R3 done at 32nd edge", {31'b0, done}, 1);
    chk("R4 taps result", {24'b0, result}, 32'h79);
    tick();
    chk("R3 done single cycle", {31'b0, done}, 0);

    // R5 lane select: engine0 key 0x42
    runTo(32'h00000001, 32'h00000042, 1'b1, 32'h0);
    chk("R5 lane select result", {24'b0, result}, 32'h02);

    // R10 load and start together with nonzero seeds
    runTo(32'hA5C3_0F1E, 32'h8D21_F04C, 1'b1, 32'h1234_5678);
    chk("R10 done", {31'b0, done}, 1);

    // R7 chained run without seed load
    runTo(32'h0BAD_F00D, 32'h7E3C_91A2, 1'b0, 32'hFFFF_FFFF);
    chk("R7 chained done", {31'b0, done}, 1);

    // R8 start and loadSeed mid-run; R9 inputs changed mid-run
    challenge = 32'h1357_9BDF; funcKey = 32'h2468_ACE0; start = 1'b1; loadSeed = 1'b1;
    seedKey = 32'hCAFE_BABE;
    tick(); start = 1'b0; loadSeed = 1'b0;
    repeat (10) tick();
    start = 1'b1; loadSeed = 1'b1; seedKey = 32'h0; challenge = 32'hFFFF_0000; funcKey = 32'h0;
    tick(); start = 1'b0; loadSeed = 1'b0;
    repeat (20) tick();
    chk("R8 no early done", {31'b0, done}, 0);
    tick();
    chk("R8 done on time", {31'b0, done}, 1);

    // random runs
    for (int n = 0; n < 60; n++) begin
      bit wl = ($urandom % 3) != 0;
      runTo($urandom, $urandom, wl, $urandom);
      if (($urandom % 4) == 0) begin
        challenge = $urandom; funcKey = $urandom;
      end
      repeat ($urandom % 3) tick();
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule